// File: doc/BRIEF.md
# Timer Software Event Generator

This block lets software raise timer events by writing a single command word. Each bit set in that word becomes a one-clock internal event pulse in the cycle after the write. The block then applies the event's effect to the timer state it owns. That state is the capture/compare interrupt flags, the update and trigger flags, the main output enable, the counter with its reload shadow, and the channel enable and mode registers that are committed by a commutation update.

Two update events exist. The counter update restarts the counter from the end that matches its count direction and refreshes the reload shadow. The commutation update moves the staged channel enables, complementary enables and output modes into their active copies, but only when the commutation-preload control bit is set. A break event first sets its flag and, one cycle later, drops the main output enable. Only a software write to the output-enable register can raise that enable again. A small register bus gives access to the support registers. The event register itself always reads as zero.

Register offsets: 0x00 control (bit 0 count down, bit 1 commutation preload), 0x04 reload staging value, 0x08 flags (write 1 to clear), 0x0C output enable (bit 0), 0x10 staged channel controls, 0x14 active channel controls (read only), 0x18 counter (read only), 0x1C active reload (read only), 0x78 event command.

Top module: `tev_top`

## Requirements
- R1: After reset the flags, main output enable, counter, active reload and active channel controls are all zero, and no event pulse is driven.
- R2: Reading offset 0x78 returns 0 in every bit. Writing 0 to any event bit raises no pulse and changes no flag.
- R3: Each 1 written to an event bit gives a pulse exactly one clock wide, starting the cycle after the write. Several bits written together pulse in the same cycle. The pulse vector carries bits [3:0] for the channel requests (command bits 3..0), bit 4 for the counter update (command bit 8), bit 5 for the commutation update (bit 9), bit 6 for the trigger (bit 10) and bit 7 for the break (bit 11).
- R4: A channel request sets that channel's flag (flag bits 3..0). Writing 1 to a flag bit at offset 0x08 clears it, and writing 0 leaves it unchanged.
- R5: A trigger event sets flag bit 5.
- R6: A break event sets flag bit 6 one cycle after its pulse, and clears the main output enable in the cycle after that. No later event sets the enable again. Only a write of 1 to bit 0 of offset 0x0C does.
- R7: A commutation update copies the staged channel controls (bits [3:0] enables, [7:4] complementary enables, [15:8] two-bit modes) into the active copy when control bit 1 is 1, and leaves the active copy unchanged when it is 0.
- R8: A counter update while counting up clears the counter, copies the staged reload into the active reload and sets flag bit 4.
- R9: A counter update while counting down loads the counter with the staged reload value.
- R10: A counter update takes precedence over a count tick or wrap that falls in the same cycle.
- R11: Command bits 7..4 and 31..12 are reserved and writing them raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cnt_tick | input | 1 | Count enable from the timer prescaler |
| evt_pulse | output | 8 | One-cycle event pulses |
| cnt_value | output | 16 | Current counter value |
| main_oe | output | 1 | Main output enable |
| ch_en | output | 4 | Active channel enables |
| ch_nen | output | 4 | Active complementary enables |
| ch_mode | output | 8 | Active channel modes, two bits per channel |
| irq_flags | output | 7 | Event flags |

## Verification
The counter update and the ordinary count tick can land on the same clock edge. The bench holds the tick high across a counter-update command, so the pulse and a live increment arrive together. It then expects the counter to read zero rather than the incremented value. The break's two-step effect on the main output enable is judged cycle by cycle. A later counter update is then issued to confirm that it leaves the enable low.

// File: rtl/tev_pkg.sv
package tev_pkg;
  localparam int unsigned OFS_CTRL = 32'h00;
  localparam int unsigned OFS_RLD  = 32'h04;
  localparam int unsigned OFS_STS  = 32'h08;
  localparam int unsigned OFS_OUT  = 32'h0C;
  localparam int unsigned OFS_CHP  = 32'h10;
  localparam int unsigned OFS_CHA  = 32'h14;
  localparam int unsigned OFS_CNT  = 32'h18;
  localparam int unsigned OFS_RLA  = 32'h1C;
  localparam int unsigned OFS_EVG  = 32'h78;
  // command bit positions decoded by the capture stage
  localparam int unsigned CMD_UPD1 = 8;
  localparam int unsigned CMD_UPD2 = 9;
  localparam int unsigned CMD_TRIG = 10;
  localparam int unsigned CMD_BRK  = 11;
  // flag layout
  localparam int unsigned CC_SLOTS = 4;
  localparam int unsigned FLG_UPD  = 4;
  localparam int unsigned FLG_TRIG = 5;
  localparam int unsigned FLG_BRK  = 6;
  localparam int unsigned FLG_W    = 7;
endpackage

// File: rtl/tev_capture.sv
module tev_capture #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic [NCH-1:0] cc_req,
  input  logic [3:0]     sys_req,
  output logic [NCH-1:0] cc_ev,
  output logic           upd1_ev,
  output logic           upd2_ev,
  output logic           trig_ev,
  output logic           brk_ev
);
  logic [NCH+3:0] ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   ev_q <= '0;
    else if (hit) ev_q <= {sys_req, cc_req};
    else          ev_q <= '0;
  end

  assign cc_ev   = ev_q[NCH-1:0];
  assign upd1_ev = ev_q[NCH];
  assign upd2_ev = ev_q[NCH+1];
  assign trig_ev = ev_q[NCH+2];
  assign brk_ev  = ev_q[NCH+3];

  AST_BRK_PULSE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    hit && sys_req[3] |=> brk_ev) else $error("break pulse missing"); // R3
endmodule

// File: rtl/tev_counter.sv
module tev_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             upd1_ev,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] rld_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld_pre,
  output logic [CNT_W-1:0] rld_act,
  output logic             upd_set
);
  logic wrap, ovf;

  always_comb begin
    wrap    = down ? (cnt == '0) : (cnt == rld_act);
    ovf     = tick && !upd1_ev && wrap;
    upd_set = upd1_ev || ovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      rld_pre <= '0;
      rld_act <= '0;
    end else begin
      if (rld_wr) rld_pre <= rld_wdata;
      if (upd_set) rld_act <= rld_pre;
      if (upd1_ev)   cnt <= down ? rld_pre : '0;
      else if (tick) begin
        if (wrap)      cnt <= down ? rld_pre : '0;
        else if (down) cnt <= cnt - CNT_W'(1);
        else           cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_UPD1_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    upd1_ev && !down |=> cnt == '0) else $error("up restart"); // R8
  AST_UPD1_DOWN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    upd1_ev && down |=> cnt == $past(rld_pre)) else $error("down restart"); // R9
  AST_UPD1_OVER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    upd1_ev && tick && !down |=> cnt == '0) else $error("tick won"); // R10
endmodule

// File: rtl/tev_chan.sv
module tev_chan #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned MODE_W = 2,
  localparam int unsigned PRE_W = NCH * (2 + MODE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_wr,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic             upd2_ev,
  input  logic             compre,
  output logic [PRE_W-1:0] ch_pre,
  output logic [PRE_W-1:0] ch_act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_pre <= '0;
      ch_act <= '0;
    end else begin
      if (pre_wr) ch_pre <= pre_wdata;
      if (upd2_ev && compre) ch_act <= ch_pre;
    end
  end

  AST_UPD2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    upd2_ev && !compre |=> $stable(ch_act)) else $error("ungated commit"); // R7
endmodule

// File: rtl/tev_flags.sv
module tev_flags #(
  parameter int unsigned NCH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            cc_ev,
  input  logic                      upd_set,
  input  logic                      trig_ev,
  input  logic                      brk_ev,
  input  logic                      clr_wr,
  input  logic [tev_pkg::FLG_W-1:0] clr_mask,
  input  logic                      out_wr,
  input  logic                      out_bit,
  output logic [tev_pkg::FLG_W-1:0] flags,
  output logic                      main_oe
);
  import tev_pkg::*;
  logic [FLG_W-1:0] set_vec, clr_vec;
  logic             brk_d;

  always_comb begin
    set_vec = {brk_ev, trig_ev, upd_set, CC_SLOTS'(cc_ev)};
    clr_vec = clr_wr ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      brk_d   <= 1'b0;
      main_oe <= 1'b0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      brk_d <= brk_ev;
      if (brk_d)       main_oe <= 1'b0;
      else if (out_wr) main_oe <= out_bit;
    end
  end

  AST_BRK_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev |=> flags[FLG_BRK]) else $error("break flag"); // R6
  AST_MOE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev |=> ##1 !main_oe) else $error("enable kept"); // R6
  AST_MOE_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !main_oe && !out_wr |=> !main_oe) else $error("enable restored"); // R6
  AST_TRIG_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ev |=> flags[FLG_TRIG]) else $error("trigger flag"); // R5
endmodule

// File: rtl/tev_top.sv
module tev_top #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NCH    = 4,
  parameter int unsigned MODE_W = 2,
  localparam int unsigned PRE_W = NCH * (2 + MODE_W),
  localparam int unsigned EV_W  = NCH + 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      cnt_tick,
  output logic [EV_W-1:0]           evt_pulse,
  output logic [CNT_W-1:0]          cnt_value,
  output logic                      main_oe,
  output logic [NCH-1:0]            ch_en,
  output logic [NCH-1:0]            ch_nen,
  output logic [NCH*MODE_W-1:0]     ch_mode,
  output logic [tev_pkg::FLG_W-1:0] irq_flags
);
  import tev_pkg::*;

  logic             wr_ctrl, wr_rld, wr_sts, wr_out, wr_chp, wr_evg;
  logic             ctl_down, ctl_compre;
  logic [NCH-1:0]   cc_ev;
  logic             upd1_ev, upd2_ev, trig_ev, brk_ev, upd_set;
  logic [CNT_W-1:0] rld_pre, rld_act;
  logic [PRE_W-1:0] ch_pre, ch_act;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    wr_rld  = bus_wr && (bus_addr == ADDR_W'(OFS_RLD));
    wr_sts  = bus_wr && (bus_addr == ADDR_W'(OFS_STS));
    wr_out  = bus_wr && (bus_addr == ADDR_W'(OFS_OUT));
    wr_chp  = bus_wr && (bus_addr == ADDR_W'(OFS_CHP));
    wr_evg  = bus_wr && (bus_addr == ADDR_W'(OFS_EVG));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_down   <= 1'b0;
      ctl_compre <= 1'b0;
    end else if (wr_ctrl) begin
      ctl_down   <= bus_wdata[0];
      ctl_compre <= bus_wdata[1];
    end
  end

  tev_capture #(.NCH(NCH)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit(wr_evg),
    .cc_req(bus_wdata[NCH-1:0]),
    .sys_req({bus_wdata[CMD_BRK], bus_wdata[CMD_TRIG], bus_wdata[CMD_UPD2], bus_wdata[CMD_UPD1]}),
    .cc_ev(cc_ev), .upd1_ev(upd1_ev), .upd2_ev(upd2_ev), .trig_ev(trig_ev), .brk_ev(brk_ev)
  );

  tev_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .down(ctl_down), .upd1_ev(upd1_ev),
    .rld_wr(wr_rld), .rld_wdata(bus_wdata[CNT_W-1:0]),
    .cnt(cnt_value), .rld_pre(rld_pre), .rld_act(rld_act), .upd_set(upd_set)
  );

  tev_chan #(.NCH(NCH), .MODE_W(MODE_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .pre_wr(wr_chp), .pre_wdata(bus_wdata[PRE_W-1:0]),
    .upd2_ev(upd2_ev), .compre(ctl_compre), .ch_pre(ch_pre), .ch_act(ch_act)
  );

  tev_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .cc_ev(cc_ev), .upd_set(upd_set), .trig_ev(trig_ev),
    .brk_ev(brk_ev), .clr_wr(wr_sts), .clr_mask(bus_wdata[FLG_W-1:0]),
    .out_wr(wr_out), .out_bit(bus_wdata[0]), .flags(irq_flags), .main_oe(main_oe)
  );

  assign evt_pulse = {brk_ev, trig_ev, upd2_ev, upd1_ev, cc_ev};
  assign ch_en     = ch_act[NCH-1:0];
  assign ch_nen    = ch_act[2*NCH-1:NCH];
  assign ch_mode   = ch_act[PRE_W-1:2*NCH];

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = {30'b0, ctl_compre, ctl_down};
    else if (bus_addr == ADDR_W'(OFS_RLD))  bus_rdata = 32'(rld_pre);
    else if (bus_addr == ADDR_W'(OFS_STS))  bus_rdata = 32'(irq_flags);
    else if (bus_addr == ADDR_W'(OFS_OUT))  bus_rdata = 32'(main_oe);
    else if (bus_addr == ADDR_W'(OFS_CHP))  bus_rdata = 32'(ch_pre);
    else if (bus_addr == ADDR_W'(OFS_CHA))  bus_rdata = 32'(ch_act);
    else if (bus_addr == ADDR_W'(OFS_CNT))  bus_rdata = 32'(cnt_value);
    else if (bus_addr == ADDR_W'(OFS_RLA))  bus_rdata = 32'(rld_act);
  end
endmodule

// File: tb/tev_top_tb.sv
module tev_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cnt_tick = 1'b0;
  logic [7:0]  evt_pulse;
  logic [15:0] cnt_value;
  logic        main_oe;
  logic [3:0]  ch_en, ch_nen;
  logic [7:0]  ch_mode;
  logic [6:0]  irq_flags;

  int n_total = 0;
  int n_pass  = 0;

  typedef struct {
    string       req;
    logic [7:0]  addr;
    logic [31:0] exp;
  } exp_item_t;
  exp_item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  tev_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
    .evt_pulse(evt_pulse), .cnt_value(cnt_value), .main_oe(main_oe),
    .ch_en(ch_en), .ch_nen(ch_nen), .ch_mode(ch_mode), .irq_flags(irq_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
  endtask

  task automatic push_exp(input string req, input logic [7:0] a, input logic [31:0] e);
    exp_item_t it;
    it.req = req; it.addr = a; it.exp = e;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin
      exp_item_t it;
      it = exp_q.pop_front();
      bus_addr = it.addr;
      #1;
      chk(it.req, bus_rdata, it.exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pulse", 32'(evt_pulse), 0);
    push_exp("R1 flags", 8'h08, 0);
    push_exp("R1 oe", 8'h0C, 0);
    push_exp("R1 cnt", 8'h18, 0);
    push_exp("R1 chact", 8'h14, 0);
    push_exp("R1 rldact", 8'h1C, 0);
    drain();

    bus_write(8'h0C, 1);
    bus_write(8'h04, 10);
    push_exp("R2 evg read", 8'h78, 0);
    drain();

    // R8 counter update counting up
    bus_write(8'h78, 32'h100);
    chk("R3 upd1 pulse", 32'(evt_pulse), 32'h10);
    @(negedge clk);
    push_exp("R8 cnt", 8'h18, 0);
    push_exp("R8 rldact", 8'h1C, 10);
    push_exp("R8 upd flag", 8'h08, 32'h10);
    drain();
    bus_write(8'h08, 32'h7F);

    // R2 zero write
    bus_write(8'h78, 0);
    chk("R2 zero pulse", 32'(evt_pulse), 0);
    @(negedge clk);
    push_exp("R2 flags", 8'h08, 0);
    drain();

    // R3/R4 channel requests
    bus_write(8'h78, 32'h5);
    chk("R3 cc pulse", 32'(evt_pulse), 32'h5);
    @(negedge clk);
    chk("R3 one cycle", 32'(evt_pulse), 0);
    push_exp("R4 cc flags", 8'h08, 32'h5);
    drain();
    bus_write(8'h08, 32'h1);
    push_exp("R4 w1c", 8'h08, 32'h4);
    drain();

    // R3/R5 several at once
    bus_write(8'h78, 32'h402);
    chk("R3 multi pulse", 32'(evt_pulse), 32'h42);
    @(negedge clk);
    push_exp("R5 trig flag", 8'h08, 32'h26);
    drain();
    bus_write(8'h08, 32'h7F);

    // R11 reserved bits
    bus_write(8'h78, 32'hFFFF_F0F0);
    chk("R11 pulse", 32'(evt_pulse), 0);
    @(negedge clk);
    push_exp("R11 flags", 8'h08, 0);
    drain();

    // R6 break
    bus_write(8'h78, 32'h800);
    chk("R3 brk pulse", 32'(evt_pulse), 32'h80);
    @(negedge clk);
    push_exp("R6 brk flag", 8'h08, 32'h40);
    drain();
    chk("R6 oe still high", 32'(main_oe), 1);
    @(negedge clk);
    chk("R6 oe dropped", 32'(main_oe), 0);
    bus_write(8'h78, 32'h100);
    @(negedge clk);
    @(negedge clk);
    chk("R6 update no restore", 32'(main_oe), 0);
    bus_write(8'h0C, 1);
    chk("R6 sw restore", 32'(main_oe), 1);

    // R7 commutation update
    bus_write(8'h10, 32'hA5C3);
    bus_write(8'h78, 32'h200);
    @(negedge clk);
    chk("R7 gated off", {16'b0, ch_mode, ch_nen, ch_en}, 0);
    push_exp("R7 chact off", 8'h14, 0);
    drain();
    bus_write(8'h00, 32'h2);
    bus_write(8'h78, 32'h200);
    @(negedge clk);
    chk("R7 committed", {16'b0, ch_mode, ch_nen, ch_en}, 32'hA5C3);
    push_exp("R7 chact on", 8'h14, 32'hA5C3);
    drain();

    // R10 update against a live tick
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (2) @(negedge clk);
    bus_write(8'h78, 32'h100);
    chk("R10 counting", 32'(cnt_value), 4);
    @(negedge clk);
    chk("R10 update wins", 32'(cnt_value), 0);
    cnt_tick = 1'b0;

    // R9 counter update counting down
    bus_write(8'h00, 32'h1);
    bus_write(8'h04, 7);
    bus_write(8'h78, 32'h100);
    @(negedge clk);
    chk("R9 down load", 32'(cnt_value), 7);
    push_exp("R9 rldact", 8'h1C, 7);
    drain();

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule